// File: doc/BRIEF.md
# Packed Saturating Add/Subtract Unit

This unit performs element-wise addition or subtraction on two 64-bit operands that each hold a vector of small integers. A size control splits the word into eight 8-bit elements or four 16-bit elements. Every element is computed on its own, with no carry or borrow crossing from one element into its neighbour. The same operation is applied to all elements in the same cycle.

Each element can either wrap around modulo its width or clamp to the limits of its range. Clamping can treat the elements as unsigned or as two's-complement signed. A flag per element reports that clamping replaced the arithmetic result. Both the packed result and the flags are registered, so they appear one clock after the operands. Typical uses are pixel blending and audio mixing, where a clamped result looks or sounds better than one that wraps.

Top module: `simd_sat_alu`

## Requirements
- R1: With `lane16_i`=0, `sat_i`=0 and `sub_i`=0, byte k of `res_o` (bits 8k+7..8k, k=0..7) equals (byte k of a + byte k of b) mod 256. No carry enters byte k+1.
- R2: With `lane16_i`=1, element k occupies bits 16k+15..16k (k=0..3). With `sat_i`=0 and `sub_i`=0, it equals (a+b) mod 65536. The carry crosses the byte boundary inside an element but never into the next element.
- R3: With `sub_i`=1 and `sat_i`=0, each element equals (a−b) mod 2^W at the selected width W. No borrow leaves the element.
- R4: With `sat_i`=1 and `signed_i`=0, an element whose true sum exceeds 2^W−1 becomes all ones. An element whose true difference is below 0 becomes 0.
- R5: With `sat_i`=1 and `signed_i`=1, an element whose true result exceeds 2^(W−1)−1 becomes that maximum (0x7F or 0x7FFF). An element whose true result is below −2^(W−1) becomes that minimum (0x80 or 0x8000).
- R6: Bit k of `sat_flag_o` is 1 exactly when element k was clamped. All flags are 0 when `sat_i`=0. With `lane16_i`=1, bits 7..4 are 0.
- R7: While reset is active, `res_o` and `sat_flag_o` are 0. Outside reset, the outputs reflect the inputs sampled at the previous rising clock edge and do not change between edges.
- R8: `signed_i` has no effect when `sat_i`=0. The wrapped result is the same for either value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized internally |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand (subtrahend when subtracting) |
| lane16_i | input | 1 | Element size: 0 = eight 8-bit, 1 = four 16-bit |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| sat_i | input | 1 | 0 = wrap-around, 1 = clamp |
| signed_i | input | 1 | Clamp range: 0 = unsigned, 1 = signed |
| res_o | output | 64 | Registered packed result |
| sat_flag_o | output | 8 | Registered per-element clamp flags |

## Verification
The properties assume that every input carries a defined 0 or 1 at each rising edge. They check their relations only while the internally synchronized reset is released; the reset property alone watches the reset window. All sixteen combinations of the four control inputs are treated as legal, so the properties make no assumption about which modes follow one another. The stimulus changes every input only on the falling clock edge. Operands are chosen to land exactly on and just past each element's range limits in both directions, for both element sizes.

// File: rtl/simd_pkg.sv
package simd_pkg;
  parameter int DATA_W = 64;
  parameter int EL_W   = 8;
  parameter int GRP    = 2;

  typedef enum logic {
    LANE_NARROW = 1'b0,
    LANE_WIDE   = 1'b1
  } lane_sz_e;

  function automatic logic [EL_W*GRP-1:0] wide_max(input logic sgn);
    logic [EL_W*GRP-1:0] v;
    v = '1;
    if (sgn) v[EL_W*GRP-1] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/simd_rst_sync.sv
module simd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/simd_byte_slice.sv
module simd_byte_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         a_msb_o,
  output logic         bx_msb_o
);
  logic [W-1:0] bx;
  logic [W:0]   full;

  always_comb begin
    bx       = sub_i ? ~b_i : b_i;
    full     = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cin_i};
    sum_o    = full[W-1:0];
    cout_o   = full[W];
    a_msb_o  = a_i[W-1];
    bx_msb_o = bx[W-1];
  end
endmodule

// File: rtl/simd_addsub_core.sv
module simd_addsub_core #(
  parameter int DW   = 64,
  parameter int EW   = 8,
  parameter int GRP  = 2
) (
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic             sub_i,
  input  logic             wide_i,
  output logic [DW-1:0]    sum_o,
  output logic [DW/EW-1:0] cout_o,
  output logic [DW/EW-1:0] a_msb_o,
  output logic [DW/EW-1:0] bx_msb_o
);
  localparam int NS = DW / EW;

  logic [NS-1:0] cin;

  for (genvar s = 0; s < NS; s++) begin : g_slice
    if ((s % GRP) == 0) begin : g_head
      assign cin[s] = sub_i;
    end else begin : g_body
      assign cin[s] = wide_i ? cout_o[s-1] : sub_i;
    end

    simd_byte_slice #(.W(EW)) u_slice (
      .a_i      (a_i[s*EW +: EW]),
      .b_i      (b_i[s*EW +: EW]),
      .sub_i    (sub_i),
      .cin_i    (cin[s]),
      .sum_o    (sum_o[s*EW +: EW]),
      .cout_o   (cout_o[s]),
      .a_msb_o  (a_msb_o[s]),
      .bx_msb_o (bx_msb_o[s])
    );
  end
endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] sum_i,
  input  logic          a_msb_i,
  input  logic          bx_msb_i,
  input  logic          cout_i,
  input  logic          sub_i,
  input  logic          sat_i,
  input  logic          signed_i,
  output logic [LW-1:0] res_o,
  output logic          hit_o
);
  logic          ovf_u;
  logic          ovf_s;
  logic [LW-1:0] lim;

  always_comb begin
    ovf_u = sub_i ? ~cout_i : cout_i;
    ovf_s = (a_msb_i == bx_msb_i) && (sum_i[LW-1] != a_msb_i);
    hit_o = sat_i && (signed_i ? ovf_s : ovf_u);

    if (signed_i) begin
      lim         = a_msb_i ? '0 : '1;
      lim[LW-1]   = a_msb_i;
    end else begin
      lim = sub_i ? '0 : '1;
    end

    res_o = hit_o ? lim : sum_i;
  end
endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu #(
  parameter int DW = simd_pkg::DATA_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DW-1:0]              a_i,
  input  logic [DW-1:0]              b_i,
  input  logic                       lane16_i,
  input  logic                       sub_i,
  input  logic                       sat_i,
  input  logic                       signed_i,
  output logic [DW-1:0]              res_o,
  output logic [DW/simd_pkg::EL_W-1:0] sat_flag_o
);
  import simd_pkg::*;

  localparam int NW  = EL_W;
  localparam int WW  = EL_W * GRP;
  localparam int NN  = DW / NW;
  localparam int NWD = DW / WW;

  logic          rst_sync_n;
  logic [DW-1:0] sum_w;
  logic [NN-1:0] cout_w;
  logic [NN-1:0] amsb_w;
  logic [NN-1:0] bmsb_w;
  logic [DW-1:0] r_narrow;
  logic [DW-1:0] r_wide;
  logic [NN-1:0] f_narrow;
  logic [NWD-1:0] f_wide;
  lane_sz_e      size_sel;

  logic [DW-1:0] res_d, res_q;
  logic [NN-1:0] flg_d, flg_q;

  simd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  simd_addsub_core #(.DW(DW), .EW(NW), .GRP(GRP)) u_core (
    .a_i      (a_i),
    .b_i      (b_i),
    .sub_i    (sub_i),
    .wide_i   (lane16_i),
    .sum_o    (sum_w),
    .cout_o   (cout_w),
    .a_msb_o  (amsb_w),
    .bx_msb_o (bmsb_w)
  );

  for (genvar n = 0; n < NN; n++) begin : g_narrow
    simd_lane_clamp #(.LW(NW)) u_clamp (
      .sum_i    (sum_w[n*NW +: NW]),
      .a_msb_i  (amsb_w[n]),
      .bx_msb_i (bmsb_w[n]),
      .cout_i   (cout_w[n]),
      .sub_i    (sub_i),
      .sat_i    (sat_i),
      .signed_i (signed_i),
      .res_o    (r_narrow[n*NW +: NW]),
      .hit_o    (f_narrow[n])
    );
  end

  for (genvar w = 0; w < NWD; w++) begin : g_wide
    localparam int TOP = w*GRP + GRP - 1;
    simd_lane_clamp #(.LW(WW)) u_clamp (
      .sum_i    (sum_w[w*WW +: WW]),
      .a_msb_i  (amsb_w[TOP]),
      .bx_msb_i (bmsb_w[TOP]),
      .cout_i   (cout_w[TOP]),
      .sub_i    (sub_i),
      .sat_i    (sat_i),
      .signed_i (signed_i),
      .res_o    (r_wide[w*WW +: WW]),
      .hit_o    (f_wide[w])
    );
  end

  always_comb begin
    size_sel = lane_sz_e'(lane16_i);
    unique case (size_sel)
      LANE_WIDE: begin
        res_d = r_wide;
        flg_d = {{(NN-NWD){1'b0}}, f_wide};
      end
      default: begin
        res_d = r_narrow;
        flg_d = f_narrow;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  assign res_o      = res_q;
  assign sat_flag_o = flg_q;
endmodule

// File: rtl/simd_sat_alu_chk.sv
module simd_sat_alu_chk #(
  parameter int DW = 64,
  parameter int EW = 8
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic [DW-1:0]      a_i,
  input logic [DW-1:0]      b_i,
  input logic               lane16_i,
  input logic               sub_i,
  input logic               sat_i,
  input logic               signed_i,
  input logic [DW-1:0]      res_o,
  input logic [DW/EW-1:0]   sat_flag_o
);
  localparam int NN  = DW / EW;
  localparam int WW  = 2 * EW;
  localparam int NWD = DW / WW;

  assert_reset_clear_R7: assert property (@(posedge clk)
    !rst_sync_n |=> (res_o == '0 && sat_flag_o == '0));

  assert_wrap_noflag_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sat_i |=> (sat_flag_o == '0));

  assert_wide_hiflag_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lane16_i |=> (sat_flag_o[NN-1:NWD] == '0));

  for (genvar k = 0; k < NN; k++) begin : g_n
    assert_wrap_add8_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!sat_i && !lane16_i && !sub_i) |=>
        res_o[k*EW +: EW] == EW'($past(a_i[k*EW +: EW]) + $past(b_i[k*EW +: EW])));

    assert_wrap_sub8_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!sat_i && !lane16_i && sub_i) |=>
        res_o[k*EW +: EW] == EW'($past(a_i[k*EW +: EW]) - $past(b_i[k*EW +: EW])));

    assert_usat_add_floor_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sat_i && !signed_i && !lane16_i && !sub_i) |=>
        res_o[k*EW +: EW] >= $past(a_i[k*EW +: EW]));

    assert_usat_sub_ceil_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sat_i && !signed_i && !lane16_i && sub_i) |=>
        res_o[k*EW +: EW] <= $past(a_i[k*EW +: EW]));

    assert_uflag_extreme_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sat_i && !signed_i && !lane16_i) |=>
        (!sat_flag_o[k] || res_o[k*EW +: EW] == '0 || res_o[k*EW +: EW] == '1));
  end

  for (genvar w = 0; w < NWD; w++) begin : g_w
    assert_wrap_add16_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!sat_i && lane16_i && !sub_i) |=>
        res_o[w*WW +: WW] == WW'($past(a_i[w*WW +: WW]) + $past(b_i[w*WW +: WW])));

    assert_sflag_extreme_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (sat_i && signed_i && lane16_i) |=>
        (!sat_flag_o[w] || res_o[w*WW +: WW] == {1'b1, {(WW-1){1'b0}}}
                        || res_o[w*WW +: WW] == {1'b0, {(WW-1){1'b1}}}));
  end
endmodule

bind simd_sat_alu simd_sat_alu_chk #(.DW(DW), .EW(simd_pkg::EL_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .a_i        (a_i),
  .b_i        (b_i),
  .lane16_i   (lane16_i),
  .sub_i      (sub_i),
  .sat_i      (sat_i),
  .signed_i   (signed_i),
  .res_o      (res_o),
  .sat_flag_o (sat_flag_o)
);

// File: tb/sim_simd_sat_alu.sv
module sim_simd_sat_alu;
  localparam int NV = 12;
  localparam int VW = 64 + 64 + 4 + 64 + 8;

  // fields: a, b, {lane16,sub,sat,signed}, expected result, expected flags
  localparam logic [VW-1:0] TBL [NV] = '{
    {64'h01FF_7F80_0010_FE02, 64'h0101_0180_00F0_0203, 4'b0000, 64'h0200_8000_0000_0005, 8'h00}, // R1
    {64'h01FF_7F80_0010_FE02, 64'h0101_0180_00F0_0203, 4'b1000, 64'h0300_8100_0100_0005, 8'h00}, // R2
    {64'h0500_8010_FF00_0203, 64'h0301_0120_FF01_0302, 4'b0100, 64'h02FF_7FF0_00FF_FF01, 8'h00}, // R3
    {64'h0100_0000_8000_1234, 64'h0001_0001_0001_1234, 4'b1100, 64'h00FF_FFFF_7FFF_0000, 8'h00}, // R3
    {64'hFF80_7F01_C850_0000, 64'h0180_80FE_4050_00FF, 4'b0010, 64'hFFFF_FFFF_FFA0_00FF, 8'hC8}, // R4
    {64'h0010_FF05_0080_0100, 64'h0120_0005_0081_0001, 4'b0110, 64'h0000_FF00_0000_0100, 8'hC5}, // R4
    {64'h7FFF_8000_4000_FFFF, 64'h0001_FFFF_4000_0001, 4'b1011, 64'h7FFF_8000_7FFF_0000, 8'h0E}, // R5
    {64'h807F_0010_FF7F_8005, 64'h01FF_0120_7F80_8005, 4'b0111, 64'h807F_FFF0_807F_0000, 8'hC4}, // R5
    {64'h0000_FFFF_1234_0100, 64'h0001_FFFF_1235_00FF, 4'b1110, 64'h0000_0000_0000_0001, 8'h0A}, // R4
    {64'hFFFF_8000_00FF_0001, 64'h0001_8000_0001_0002, 4'b1010, 64'hFFFF_FFFF_0100_0003, 8'h0C}, // R4
    {64'hFF80_7F01_C850_0000, 64'h0180_80FE_4050_00FF, 4'b0001, 64'h0000_FFFF_08A0_00FF, 8'h00}, // R8
    {64'h8000_7FFF_0000_8000, 64'h0001_FFFF_8000_8000, 4'b1111, 64'h8000_7FFF_7FFF_0000, 8'h0E}  // R5
  };

  logic        clk;
  logic        rst_n;
  logic [63:0] a, b;
  logic        lane16, sub, sat, sgn;
  logic [63:0] res;
  logic [7:0]  flg;
  int          total;
  int          bad;
  bit          done;

  simd_sat_alu u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_i        (a),
    .b_i        (b),
    .lane16_i   (lane16),
    .sub_i      (sub),
    .sat_i      (sat),
    .signed_i   (sgn),
    .res_o      (res),
    .sat_flag_o (flg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string tag_of(input int i);
    case (i)
      0:       return "R1";
      1:       return "R2";
      2, 3:    return "R3";
      6, 7, 11: return "R5";
      10:      return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input int i);
    {a, b, lane16, sub, sat, sgn} = TBL[i][VW-1:72];
  endtask

  initial begin
    total  = 0;
    bad    = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    a      = 64'h1234_5678_9ABC_DEF0;
    b      = 64'hFFFF_FFFF_FFFF_FFFF;
    lane16 = 1'b0;
    sub    = 1'b0;
    sat    = 1'b1;
    sgn    = 1'b0;
    repeat (4) @(negedge clk);
    check("R7 reset result", res, 64'h0);
    check("R7 reset flags", {56'h0, flg}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(i);
      @(negedge clk);
      check(tag_of(i), res, TBL[i][71:8]);
      check("R6 flags", {56'h0, flg}, {56'h0, TBL[i][7:0]});
    end

    // R7: output holds the previous result until the next rising edge
    apply(0);
    @(negedge clk);
    apply(1);
    #2;
    check("R7 hold between edges", res, TBL[0][71:8]);
    @(negedge clk);
    check("R7 one-cycle update", res, TBL[1][71:8]);

    // R8: same operands wrap identically with signed_i low
    apply(10);
    sgn = 1'b0;
    @(negedge clk);
    check("R8 signed ignored", res, TBL[10][71:8]);

    // R6: wide mode flags never reach upper bits even with every lane clamped
    a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h0001_0001_0001_0001;
    lane16 = 1'b1; sub = 1'b0; sat = 1'b1; sgn = 1'b0;
    @(negedge clk);
    check("R6 all wide lanes clamped", {56'h0, flg}, 64'h0F);
    check("R4 wide clamp to max", res, 64'hFFFF_FFFF_FFFF_FFFF);

    // R7: reset in mid-run clears outputs at once
    rst_n = 1'b0;
    #2;
    check("R7 async clear result", res, 64'h0);
    check("R7 async clear flags", {56'h0, flg}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule